// File: doc/BRIEF.md
# Incremental PID Controller Datapath

This block computes a discrete PID control value in velocity form, one update per sample strobe. On each strobe it takes an 8-bit setpoint and an 8-bit measured feedback value, both unsigned, and subtracts them to form the control error. It combines that error with the two previous errors and the previous output through three signed fixed-point coefficients. The result is clamped to an 8-bit unsigned code that can drive a DAC directly.

The coefficients are computed offline from the loop gain kp, the sample period T and the time constants Ti and Td:

- the current-error weight is kp·(1 + T/Ti + Td/T);
- the one-step-old weight is −kp·(1 + 2·Td/T);
- the two-step-old weight is kp·Td/T.

They are then presented on the coefficient ports in signed Q8.8. The whole update is one cycle of parallel combinational arithmetic, with three multipliers and a summing tree. It is stored in three history registers: the last error, the error before it, and the last output.

Top module: `incr_pid_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the last output, both stored errors and `result_valid` to zero; a first update after reset sees zero history.
- R2: The error is e = setpoint − feedback, both inputs being unsigned 8-bit codes, giving a signed value from −255 to +255.
- R3: On a strobe the new output is clamp(u_prev + ((c0·e + c1·e1 + c2·e2) >>> 8)). The three products are summed at full width and then shifted right arithmetically (floor). The coefficients c0, c1 and c2 are signed 16-bit Q8.8, so 256 means 1.0.
- R4: Without a strobe, no change on setpoint, feedback or coefficients alters `u_out` or any stored history.
- R5: `result_valid` is high in exactly the cycle after each cycle in which `sample_valid` was high at the clock edge, and low otherwise.
- R6: A sum above 255 is stored and driven as 255.
- R7: A sum below 0 is stored and driven as 0.
- R8: On each strobe the old last error moves into the two-step-old slot, and the current error becomes the last error. The error history and the last output update in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Sample strobe; one update per high cycle |
| setpoint | input | 8 | Target value, unsigned |
| feedback | input | 8 | Measured value, unsigned |
| coef_c0 | input | 16 | Current-error weight, signed Q8.8 |
| coef_c1 | input | 16 | One-step-old error weight, signed Q8.8 |
| coef_c2 | input | 16 | Two-step-old error weight, signed Q8.8 |
| u_out | output | 8 | Clamped control output, unsigned |
| result_valid | output | 1 | High the cycle after a strobe |

## Verification
The bench targets the following corner cases:

- **Rounding of negative fractional products.** A coefficient of −0.5 applied to an odd error must round toward minus infinity. A design that truncates toward zero lands one code high.
- **Clamping at both rails.** It drives the sum past both ends. A design without clamping wraps modulo 256, and a design that clamps only the output but stores the raw sum winds up on the following updates.
- **History ordering.** Isolating each coefficient exposes a design that swaps the two stored errors or shifts them without a strobe.
- **Idle inputs.** Changing the inputs between strobes catches any update that leaks through while `sample_valid` is low.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int PID_SAMPLE_W = 8;
    localparam int PID_COEF_W   = 16;
    localparam int PID_FRAC_W   = 8;
    localparam int PID_TAPS     = 3;
endpackage

// File: rtl/pid_err_sub.sv
module pid_err_sub #(
    parameter int SAMPLE_W = pid_pkg::PID_SAMPLE_W,
    localparam int ERR_W   = SAMPLE_W + 1
) (
    input  logic [SAMPLE_W-1:0] setpoint_i,
    input  logic [SAMPLE_W-1:0] feedback_i,
    output logic [ERR_W-1:0]    err_o
);
    // zero-extended subtraction yields the two's complement difference
    always_comb begin
        err_o = {1'b0, setpoint_i} - {1'b0, feedback_i};
    end
endmodule

// File: rtl/pid_mac3.sv
module pid_mac3 #(
    parameter int ERR_W  = pid_pkg::PID_SAMPLE_W + 1,
    parameter int COEF_W = pid_pkg::PID_COEF_W,
    parameter int FRAC_W = pid_pkg::PID_FRAC_W,
    parameter int OUT_W  = pid_pkg::PID_SAMPLE_W,
    parameter int TAPS   = pid_pkg::PID_TAPS
) (
    input  logic [TAPS-1:0][ERR_W-1:0]  err_i,
    input  logic [TAPS-1:0][COEF_W-1:0] coef_i,
    input  logic [OUT_W-1:0]            u_prev_i,
    output logic [OUT_W-1:0]            u_next_o
);
    localparam int PROD_W = ERR_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAPS) + 1;
    localparam logic signed [ACC_W:0] U_MAX = (ACC_W+1)'((1 << OUT_W) - 1);

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [ACC_W:0]    total;

    // one multiplier per tap, all in parallel
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign prod[t] = PROD_W'($signed(err_i[t])) * PROD_W'($signed(coef_i[t]));
    end

    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++) begin
            acc = acc + ACC_W'(prod[t]);
        end
        scaled = acc >>> FRAC_W;
        total  = (ACC_W+1)'(scaled) + (ACC_W+1)'($signed({1'b0, u_prev_i}));
        if (total < 0) begin
            u_next_o = '0;
        end else if (total > U_MAX) begin
            u_next_o = '1;
        end else begin
            u_next_o = total[OUT_W-1:0];
        end
    end

    // clamp bounds: a negative total must give 0, an oversized one all ones
    always_comb begin
        if (total < 0) begin
            assert (u_next_o == '0) else $error("p_clamp_low_r7");
        end
        if (total > U_MAX) begin
            assert (u_next_o == '1) else $error("p_clamp_high_r6");
        end
    end
endmodule

// File: rtl/incr_pid_core.sv
module incr_pid_core #(
    parameter int SAMPLE_W = pid_pkg::PID_SAMPLE_W,
    parameter int COEF_W   = pid_pkg::PID_COEF_W,
    parameter int FRAC_W   = pid_pkg::PID_FRAC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] setpoint,
    input  logic [SAMPLE_W-1:0] feedback,
    input  logic [COEF_W-1:0]   coef_c0,
    input  logic [COEF_W-1:0]   coef_c1,
    input  logic [COEF_W-1:0]   coef_c2,
    output logic [SAMPLE_W-1:0] u_out,
    output logic                result_valid
);
    localparam int ERR_W = SAMPLE_W + 1;
    localparam int TAPS  = pid_pkg::PID_TAPS;

    typedef struct packed {
        logic [ERR_W-1:0]    e1;
        logic [ERR_W-1:0]    e2;
        logic [SAMPLE_W-1:0] u;
        logic                vld;
    } hist_t;

    hist_t st_d, st_q;
    logic [ERR_W-1:0]              err_now;
    logic [SAMPLE_W-1:0]           u_next;
    logic [TAPS-1:0][ERR_W-1:0]    taps_err;
    logic [TAPS-1:0][COEF_W-1:0]   taps_coef;

    pid_err_sub #(.SAMPLE_W(SAMPLE_W)) u_sub (
        .setpoint_i (setpoint),
        .feedback_i (feedback),
        .err_o      (err_now)
    );

    assign taps_err  = {st_q.e2, st_q.e1, err_now};
    assign taps_coef = {coef_c2, coef_c1, coef_c0};

    pid_mac3 #(
        .ERR_W  (ERR_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W),
        .OUT_W  (SAMPLE_W),
        .TAPS   (TAPS)
    ) u_mac (
        .err_i    (taps_err),
        .coef_i   (taps_coef),
        .u_prev_i (st_q.u),
        .u_next_o (u_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = sample_valid;
        if (sample_valid) begin
            st_d.e2 = st_q.e1;
            st_d.e1 = err_now;
            st_d.u  = u_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign u_out        = st_q.u;
    assign result_valid = st_q.vld;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (u_out == '0 && !result_valid && st_q.e1 == '0 && st_q.e2 == '0));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(u_out) && $stable(st_q.e1) && $stable(st_q.e2)));

    p_valid_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> result_valid);

    p_valid_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> !result_valid);

    p_history_shift_r8: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> (st_q.e2 == $past(st_q.e1)));

    p_zero_error_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && setpoint == feedback && st_q.e1 == '0 && st_q.e2 == '0)
        |=> $stable(u_out));
endmodule

// File: tb/sim_incr_pid_core.sv
module sim_incr_pid_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [7:0]  setpoint = '0;
    logic [7:0]  feedback = '0;
    logic [15:0] coef_c0 = '0;
    logic [15:0] coef_c1 = '0;
    logic [15:0] coef_c2 = '0;
    logic [7:0]  u_out;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    int m_e1 = 0;
    int m_e2 = 0;
    int m_u  = 0;

    always #10 clk = ~clk;

    incr_pid_core u0 (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .setpoint     (setpoint),
        .feedback     (feedback),
        .coef_c0      (coef_c0),
        .coef_c1      (coef_c1),
        .coef_c2      (coef_c2),
        .u_out        (u_out),
        .result_valid (result_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_e1 = 0; m_e2 = 0; m_u = 0;
    endtask

    // model of the update law, independent of the RTL structure
    function automatic int model_step(input int e, input int c0, input int c1, input int c2);
        longint acc;
        longint tot;
        acc = longint'(c0) * e + longint'(c1) * m_e1 + longint'(c2) * m_e2;
        acc = acc >>> 8;
        tot = acc + m_u;
        if (tot < 0) tot = 0;
        if (tot > 255) tot = 255;
        return int'(tot);
    endfunction

    task automatic do_sample(input int sp, input int fb, input int c0, input int c1,
                             input int c2, input string tag);
        int e;
        int exp_u;
        e = sp - fb;
        exp_u = model_step(e, c0, c1, c2);
        @(negedge clk);
        setpoint = 8'(sp); feedback = 8'(fb);
        coef_c0 = 16'(c0); coef_c1 = 16'(c1); coef_c2 = 16'(c2);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        m_e2 = m_e1; m_e1 = e; m_u = exp_u;
        check(u_out == 8'(exp_u), tag, int'(u_out), exp_u);
        check(result_valid == 1'b1, "R5 valid after strobe", int'(result_valid), 1);
    endtask

    task automatic t_reset();
        do_reset();
        check(u_out == 8'd0, "R1 output after reset", int'(u_out), 0);
        check(result_valid == 1'b0, "R1 valid after reset", int'(result_valid), 0);
        // only history weights: zero history gives zero output
        do_sample(90, 10, 0, 256, 256, "R1 history cleared");
    endtask

    task automatic t_proportional();
        do_reset();
        do_sample(100, 60, 256, 0, 0, "R2 R3 positive error");
        do_sample(60, 100, 256, 0, 0, "R2 R3 negative error");
        do_sample(200, 50, 256, 0, 0, "R2 R3 large error");
        do_sample(77, 77, 256, 0, 0, "R3 zero error holds");
    endtask

    task automatic t_history();
        do_reset();
        do_sample(20, 10, 0, 256, 0, "R8 first tap sees zero");
        do_sample(40, 20, 0, 256, 0, "R8 last error used");
        do_sample(15, 10, 0, 0, 256, "R8 two-step error used");
        do_sample(15, 10, 0, 0, 256, "R8 shift again");
    endtask

    task automatic t_saturation();
        do_reset();
        do_sample(255, 0, 32767, 0, 0, "R6 clamp high");
        check(u_out == 8'd255, "R6 rail value", int'(u_out), 255);
        do_sample(255, 0, 32767, 0, 0, "R6 clamp held");
        do_sample(0, 255, 32767, 0, 0, "R7 clamp low");
        check(u_out == 8'd0, "R7 rail value", int'(u_out), 0);
        // no windup: one positive step from the low rail
        do_sample(13, 0, 256, 0, 0, "R7 no windup");
    endtask

    task automatic t_floor();
        do_reset();
        do_sample(50, 0, 256, 0, 0, "R3 preload");
        do_sample(3, 0, -128, 0, 0, "R3 floor shift negative");
        check(u_out == 8'd48, "R3 floor value", int'(u_out), 48);
        do_sample(3, 0, 128, 0, 0, "R3 floor shift positive");
        // gains kp=1, T/Ti=0.5, Td/T=0.25
        do_sample(30, 20, 448, -384, 64, "R3 full three-term");
        do_sample(30, 20, 448, -384, 64, "R3 full three-term step 2");
        do_sample(30, 20, 448, -384, 64, "R3 full three-term step 3");
    endtask

    task automatic t_idle();
        logic [7:0] held;
        do_reset();
        do_sample(80, 20, 256, 0, 0, "R4 preload");
        held = u_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            setpoint = 8'(i * 37); feedback = 8'(200 - i);
            coef_c0 = 16'(1000 + i); coef_c1 = 16'(-500); coef_c2 = 16'(300);
        end
        @(negedge clk);
        check(u_out == held, "R4 output held without strobe", int'(u_out), int'(held));
        check(result_valid == 1'b0, "R5 valid low when idle", int'(result_valid), 0);
        // stored errors untouched: expose e1 and e2 through the next update
        do_sample(0, 0, 0, 256, 0, "R4 last error untouched");
        do_sample(0, 0, 0, 0, 256, "R4 older error untouched");
    endtask

    task automatic t_back_to_back();
        int e_a, e_b, u_a, u_b;
        do_reset();
        e_a = 30; e_b = 20;
        u_a = model_step(e_a, 256, 0, 0);
        m_e2 = m_e1; m_e1 = e_a; m_u = u_a;
        u_b = model_step(e_b, 256, 0, 0);
        m_e2 = m_e1; m_e1 = e_b; m_u = u_b;
        @(negedge clk);
        setpoint = 8'd40; feedback = 8'd10;
        coef_c0 = 16'd256; coef_c1 = '0; coef_c2 = '0;
        sample_valid = 1'b1;
        @(negedge clk);
        check(u_out == 8'(u_a), "R5 first of two strobes", int'(u_out), u_a);
        setpoint = 8'd30;
        @(negedge clk);
        sample_valid = 1'b0;
        check(u_out == 8'(u_b), "R5 second of two strobes", int'(u_out), u_b);
        check(result_valid == 1'b1, "R5 valid held for second", int'(result_valid), 1);
        @(negedge clk);
        check(result_valid == 1'b0, "R5 valid drops", int'(result_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_proportional();
        t_history();
        t_saturation();
        t_floor();
        t_idle();
        t_back_to_back();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule